// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA

This block moves outgoing frames from memory to a byte stream without processor help. Software builds a chain of 16-byte descriptors. Each descriptor names a buffer and a byte count and points to the next descriptor. Software then hands the chain over by setting an ownership bit in each one. It loads the address of the first descriptor into the pointer register and writes the command register with the send-request bit set.

The engine then works through the chain one frame at a time. For each frame it:
- reads every descriptor;
- gathers the buffer bytes into an internal frame store;
- returns each descriptor to software by clearing its ownership bit in the status word;
- streams the frame out on a byte-wide valid/ready channel, with the final byte marked.

A chain that runs into a null link before its last-flag is abandoned and no data is sent. When a frame completes, a one-cycle cause pulse reports the transmitted buffer. A separate end pulse reports that the chain has run out, and the send request is then dropped. Frames continue back to back while each pass makes progress.

Top module: `tx_desc_dma`

## Requirements
- R1: After reset, `cur_ptr` is 0, `tx_demand` is 0, `out_valid`, `mem_req` and both cause outputs are 0.
- R2: A pass starts only when the pointer is non-zero and the first descriptor has OWN (status bit 31) set. Otherwise the engine issues no memory write, emits no byte, raises no cause pulse, and leaves the pointer and `tx_demand` unchanged.
- R3: Each descriptor is 16-byte aligned and laid out as four words:
  - offset 0: size word, with the byte count in bits [31:16];
  - offset 4: status word;
  - offset 8: next pointer;
  - offset 12: buffer pointer.
  Buffers may start at any byte address. Byte n of a memory word sits in bits [8n+7:8n]. All memory accesses are word-aligned, and a request holds its address and data until `mem_ack`.
- R4: The output frame is the concatenation of every descriptor's buffer bytes in chain order. `out_last` is high on exactly its final byte.
- R5: Every consumed descriptor whose first-flag (status bit 17) is clear gets its status word, and only that word, written back with OWN cleared and all other bits kept.
- R6: After the whole chain is processed, the first descriptor's status word is written back with OWN cleared and its other bits kept.
- R7: A zero next pointer on a descriptor without the last-flag (status bit 16) aborts the frame. In that case no byte is emitted and no transmit-buffer pulse is raised, but the end pulse fires.
- R8: `cause_txbuf` pulses for one cycle after a frame of non-zero length completes. A chain whose byte counts total zero emits nothing and gives no pulse.
- R9: At the end of a pass, `cur_ptr` takes the next pointer of the last descriptor walked. If that value is zero, or the frame aborted, `cause_txend` pulses and `tx_demand` is cleared.
- R10: Writing the command register (address 1) with bit 0 set sends frames back to back. Sending stops at the first pass that makes no progress.
- R11: A frame longer than `MAX_FRAME` bytes is cut to its first `MAX_FRAME` bytes.
- R12: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold, and no byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the descriptor pointer, 1 the command register |
| reg_wdata | input | 32 | Register write data; bit 0 of the command register is the send request |
| cur_ptr | output | 32 | Current transmit descriptor pointer |
| tx_demand | output | 1 | Send-request bit of the command register |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | `out_data` is valid |
| out_last | output | 1 | Final byte of the frame |
| out_ready | input | 1 | Sink accepts the byte |
| cause_txbuf | output | 1 | One-cycle pulse: a frame was sent |
| cause_txend | output | 1 | One-cycle pulse: chain exhausted or aborted |

## Verification
The bench builds the block with `MAX_FRAME` set to 32 rather than 2048. A three-descriptor chain of 40 bytes then overflows the frame store, so the truncation rule is exercised with short runs. The smaller store also keeps every gathered byte checkable within a few hundred cycles.

Buffers start at unaligned offsets, and the sink is stalled on a fixed cadence. Together these cover lane selection, word refetch at word boundaries, and holding output under back-pressure in every frame.

// File: rtl/tx_dma_pkg.sv
// Shared constants and state encoding for the linked-descriptor transmit DMA.
// Assumes 32-bit memory words and 16-byte aligned descriptors.
package tx_dma_pkg;
    localparam int unsigned OWN_BIT   = 31;
    localparam int unsigned FIRST_BIT = 17;
    localparam int unsigned LAST_BIT  = 16;
    localparam int unsigned CNT_LSB   = 16;
    localparam int unsigned CNT_W     = 16;
    localparam logic [31:0] STATUS_OFS = 32'd4;

    typedef enum logic [3:0] {
        W_IDLE, W_DESC, W_CHECK, W_BUFRD, W_PACK,
        W_STWB, W_STEP, W_EMIT, W_FIRSTWB, W_FIN
    } walk_state_t;
endpackage

// File: rtl/tx_chan_regs.sv
// Channel registers: descriptor pointer (address 0) and command (address 1).
// A command write with bit 0 set also produces a one-cycle arm_kick.
// Assumes the walker's pointer load takes priority over a same-cycle software write.
module tx_chan_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic        ptr_load,
    input  logic [31:0] ptr_value,
    input  logic        demand_clr,
    output logic [31:0] cur_ptr,
    output logic        tx_demand,
    output logic        arm_kick
);
    // Descriptor pointer: loaded by the walker at end of pass or by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cur_ptr <= '0;
        else if (ptr_load)              cur_ptr <= ptr_value;
        else if (reg_wr && !reg_addr)   cur_ptr <= reg_wdata;
    end

    // Send-request bit: software write wins over a walker clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     tx_demand <= 1'b0;
        else if (reg_wr && reg_addr)    tx_demand <= reg_wdata[0];
        else if (demand_clr)            tx_demand <= 1'b0;
    end

    // Kick the walker whenever a send request is written.
    assign arm_kick = reg_wr && reg_addr && reg_wdata[0];
endmodule

// File: rtl/tx_frame_buf.sv
// Frame store: collects gathered bytes, then plays them out on a valid/ready stream.
// Bytes beyond DEPTH are dropped. DEPTH must be a power of two.
module tx_frame_buf #(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [7:0]       wr_byte,
    output logic [LEN_W-1:0] len,
    input  logic             emit_start,
    output logic [7:0]       out_data,
    output logic             out_valid,
    output logic             out_last,
    input  logic             out_ready,
    output logic             emit_done
);
    logic [7:0]       store [DEPTH];
    logic [LEN_W-1:0] rd_idx;
    logic             emitting;
    logic             has_room;

    assign has_room = len < LEN_W'(DEPTH);

    // Byte storage, written at the current length while room remains.
    always_ff @(posedge clk) begin
        if (wr_en && has_room) store[len[IDX_W-1:0]] <= wr_byte;
    end

    // Frame length: cleared at pass start, saturates at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)                  len <= '0;
        else if (clear)              len <= '0;
        else if (wr_en && has_room)  len <= len + 1'b1;
    end

    // Play-out pointer: advances on each accepted byte until the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emitting <= 1'b0;
            rd_idx   <= '0;
        end else if (emit_start) begin
            emitting <= 1'b1;
            rd_idx   <= '0;
        end else if (emitting && out_ready) begin
            if (out_last) emitting <= 1'b0;
            else          rd_idx   <= rd_idx + 1'b1;
        end
    end

    assign out_valid = emitting;
    assign out_data  = store[rd_idx[IDX_W-1:0]];
    assign out_last  = emitting && (rd_idx == len - 1'b1);
    assign emit_done = emitting && out_ready && out_last;
endmodule

// File: rtl/tx_desc_walker.sv
// Descriptor walker: reads descriptors, gathers buffer bytes into the frame store,
// writes back status words, and signals the end of each pass.
// Assumes one outstanding memory request; read data is valid with mem_ack.
module tx_desc_walker
    import tx_dma_pkg::*;
#(
    parameter int unsigned LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_kick,
    input  logic             tx_demand,
    input  logic [31:0]      cur_ptr,
    output logic             ptr_load,
    output logic [31:0]      ptr_value,
    output logic             demand_clr,
    output logic             cause_txbuf,
    output logic             cause_txend,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             fb_clear,
    output logic             fb_wr,
    output logic [7:0]       fb_byte,
    input  logic [LEN_W-1:0] fb_len,
    output logic             emit_start,
    input  logic             emit_done
);
    walk_state_t      state;
    logic             armed, is_first, aborted;
    logic [1:0]       word_idx;
    logic [CNT_W-1:0] d_cnt, rem;
    logic [31:0]      d_cmd, d_next, d_buf;
    logic [31:0]      desc_addr, first_addr, first_cmd, last_next;
    logic [31:0]      baddr, word_data, shifted;
    logic             go, no_own;
    walk_state_t      after_data;

    assign go         = (state == W_IDLE) && armed && tx_demand && (cur_ptr != '0);
    assign no_own     = (state == W_CHECK) && is_first && !d_cmd[OWN_BIT];
    assign after_data = d_cmd[FIRST_BIT] ? W_STEP : W_STWB;

    // Arm flag: set by a send-request write, dropped by a pass with no progress.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          armed <= 1'b0;
        else if (arm_kick)                                   armed <= 1'b1;
        else if (state == W_IDLE && tx_demand && cur_ptr == '0) armed <= 1'b0;
        else if (no_own)                                     armed <= 1'b0;
    end

    // Main walk sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= W_IDLE;
            word_idx   <= '0;
            is_first   <= 1'b0;
            aborted    <= 1'b0;
            desc_addr  <= '0;
            first_addr <= '0;
            first_cmd  <= '0;
            last_next  <= '0;
            d_cnt      <= '0;
            d_cmd      <= '0;
            d_next     <= '0;
            d_buf      <= '0;
            rem        <= '0;
            baddr      <= '0;
            word_data  <= '0;
        end else begin
            case (state)
                W_IDLE: if (go) begin
                    desc_addr  <= cur_ptr;
                    first_addr <= cur_ptr;
                    word_idx   <= '0;
                    is_first   <= 1'b1;
                    aborted    <= 1'b0;
                    state      <= W_DESC;
                end
                W_DESC: if (mem_ack) begin
                    case (word_idx)
                        2'd0:    d_cnt  <= mem_rdata[CNT_LSB +: CNT_W];
                        2'd1:    d_cmd  <= mem_rdata;
                        2'd2:    d_next <= mem_rdata;
                        default: d_buf  <= mem_rdata;
                    endcase
                    word_idx <= word_idx + 1'b1;
                    if (word_idx == 2'd3) state <= W_CHECK;
                end
                W_CHECK: begin
                    if (no_own) begin
                        state <= W_IDLE;
                    end else begin
                        if (is_first) first_cmd <= d_cmd;
                        rem   <= d_cnt;
                        baddr <= d_buf;
                        state <= (d_cnt == '0) ? after_data : W_BUFRD;
                    end
                end
                W_BUFRD: if (mem_ack) begin
                    word_data <= mem_rdata;
                    state     <= W_PACK;
                end
                W_PACK: begin
                    baddr <= baddr + 32'd1;
                    rem   <= rem - 1'b1;
                    if (rem == CNT_W'(1))         state <= after_data;
                    else if (baddr[1:0] == 2'b11) state <= W_BUFRD;
                end
                W_STWB: if (mem_ack) state <= W_STEP;
                W_STEP: begin
                    last_next <= d_next;
                    is_first  <= 1'b0;
                    if (d_cmd[LAST_BIT]) begin
                        state <= (fb_len != '0) ? W_EMIT : W_FIRSTWB;
                    end else if (d_next == '0) begin
                        aborted <= 1'b1;
                        state   <= W_FIRSTWB;
                    end else begin
                        desc_addr <= d_next;
                        word_idx  <= '0;
                        state     <= W_DESC;
                    end
                end
                W_EMIT:    if (emit_done) state <= W_FIRSTWB;
                W_FIRSTWB: if (mem_ack)   state <= W_FIN;
                W_FIN:     state <= W_IDLE;
                default:   state <= W_IDLE;
            endcase
        end
    end

    // Memory request decode from the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            W_DESC: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + {28'd0, word_idx, 2'b00};
            end
            W_BUFRD: begin
                mem_req  = 1'b1;
                mem_addr = {baddr[31:2], 2'b00};
            end
            W_STWB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + STATUS_OFS;
                mem_wdata = d_cmd & ~(32'd1 << OWN_BIT);
            end
            W_FIRSTWB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = first_addr + STATUS_OFS;
                mem_wdata = first_cmd & ~(32'd1 << OWN_BIT);
            end
            default: ;
        endcase
    end

    // Byte lane selection from the fetched word.
    assign shifted    = word_data >> {baddr[1:0], 3'b000};
    assign fb_byte    = shifted[7:0];
    assign fb_wr      = (state == W_PACK);
    assign fb_clear   = go;
    assign emit_start = (state == W_STEP) && d_cmd[LAST_BIT] && (fb_len != '0);

    // End-of-pass outputs, valid for the single W_FIN cycle.
    assign ptr_load    = (state == W_FIN);
    assign ptr_value   = last_next;
    assign cause_txbuf = (state == W_FIN) && !aborted && (fb_len != '0);
    assign cause_txend = (state == W_FIN) && (aborted || last_next == '0);
    assign demand_clr  = cause_txend;
endmodule

// File: rtl/tx_desc_dma.sv
// Top of the linked-descriptor transmit DMA: registers, walker and frame store.
// MAX_FRAME sets the frame store depth in bytes (power of two).
module tx_desc_dma #(
    parameter int unsigned MAX_FRAME = 2048,
    localparam int unsigned LEN_W = $clog2(MAX_FRAME + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] cur_ptr,
    output logic        tx_demand,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic [7:0]  out_data,
    output logic        out_valid,
    output logic        out_last,
    input  logic        out_ready,
    output logic        cause_txbuf,
    output logic        cause_txend
);
    logic             ptr_load, demand_clr, arm_kick;
    logic [31:0]      ptr_value;
    logic             fb_clear, fb_wr, emit_start, emit_done;
    logic [7:0]       fb_byte;
    logic [LEN_W-1:0] fb_len;

    tx_chan_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .ptr_load(ptr_load), .ptr_value(ptr_value), .demand_clr(demand_clr),
        .cur_ptr(cur_ptr), .tx_demand(tx_demand), .arm_kick(arm_kick)
    );

    tx_desc_walker #(.LEN_W(LEN_W)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .arm_kick(arm_kick), .tx_demand(tx_demand), .cur_ptr(cur_ptr),
        .ptr_load(ptr_load), .ptr_value(ptr_value), .demand_clr(demand_clr),
        .cause_txbuf(cause_txbuf), .cause_txend(cause_txend),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .fb_clear(fb_clear), .fb_wr(fb_wr), .fb_byte(fb_byte), .fb_len(fb_len),
        .emit_start(emit_start), .emit_done(emit_done)
    );

    tx_frame_buf #(.DEPTH(MAX_FRAME)) u_fbuf (
        .clk(clk), .rst_n(rst_n),
        .clear(fb_clear), .wr_en(fb_wr), .wr_byte(fb_byte), .len(fb_len),
        .emit_start(emit_start),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
        .out_ready(out_ready), .emit_done(emit_done)
    );
endmodule

// File: rtl/tx_desc_dma_chk.sv
// Protocol checker for tx_desc_dma, attached by bind. Observes ports only.
module tx_desc_dma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        tx_demand,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic [7:0]  out_data,
    input logic        out_valid,
    input logic        out_last,
    input logic        out_ready,
    input logic        cause_txbuf,
    input logic        cause_txend
);
    // R12: a stalled byte holds until accepted.
    a_r12_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R12: streaming and memory traffic never overlap.
    a_r12_no_mem_in_stream: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !mem_req);

    // R4: the end marker only accompanies a valid byte.
    a_r4_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R3: word-aligned accesses.
    a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    // R3: a request holds until acknowledged.
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R5: writes touch only status words, always with OWN cleared.
    a_r5_status_only: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_addr[3:0] == 4'h4 && !mem_wdata[31]);

    // R9: the end pulse drops the send request.
    a_r9_end_clears_demand: assert property (@(posedge clk) disable iff (!rst_n)
        cause_txend && !reg_wr |=> !tx_demand);

    // R8: the transmit-buffer cause is a single-cycle pulse.
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cause_txbuf |=> !cause_txbuf);
endmodule

bind tx_desc_dma tx_desc_dma_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .tx_demand(tx_demand),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
    .out_ready(out_ready), .cause_txbuf(cause_txbuf), .cause_txend(cause_txend)
);

// File: tb/tx_desc_dma_test.sv
// Self-checking bench: table-driven chains, then directed reset and corner cases.
module tx_desc_dma_test;
    localparam int unsigned MAXF = 32;
    localparam logic [31:0] OWN = 32'h8000_0000;
    localparam logic [31:0] FST = 32'h0002_0000;
    localparam logic [31:0] LST = 32'h0001_0000;

    typedef struct packed {
        logic [1:0] nd;
        logic [7:0] l0, l1, l2;
        logic [1:0] off;
        logic       term_last;
        logic [7:0] exp_len;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{nd: 2'd1, l0: 8'd5,  l1: 8'd0,  l2: 8'd0, off: 2'd0, term_last: 1'b1, exp_len: 8'd5},
        '{nd: 2'd3, l0: 8'd3,  l1: 8'd7,  l2: 8'd4, off: 2'd1, term_last: 1'b1, exp_len: 8'd14},
        '{nd: 2'd2, l0: 8'd6,  l1: 8'd2,  l2: 8'd0, off: 2'd3, term_last: 1'b0, exp_len: 8'd0},
        '{nd: 2'd1, l0: 8'd0,  l1: 8'd0,  l2: 8'd0, off: 2'd0, term_last: 1'b1, exp_len: 8'd0},
        '{nd: 2'd3, l0: 8'd20, l1: 8'd15, l2: 8'd5, off: 2'd2, term_last: 1'b1, exp_len: 8'd32},
        '{nd: 2'd2, l0: 8'd4,  l1: 8'd9,  l2: 8'd0, off: 2'd0, term_last: 1'b1, exp_len: 8'd13}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] cur_ptr;
    logic        tx_demand;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [7:0]  out_data;
    logic        out_valid, out_last, out_ready = 1'b0;
    logic        cause_txbuf, cause_txend;

    int errors = 0, checks = 0, cyc = 0;
    int nb = 0, ntb = 0, nte = 0;
    logic [7:0]  got_b [512];
    logic        got_l [512];
    logic [31:0] bmem  [256];
    logic        pk_en = 1'b0;
    logic [31:0] pk_a = '0, pk_d = '0;

    always #4 clk = ~clk;

    tx_desc_dma #(.MAX_FRAME(MAXF)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cur_ptr(cur_ptr), .tx_demand(tx_demand),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
        .out_ready(out_ready), .cause_txbuf(cause_txbuf), .cause_txend(cause_txend)
    );

    // Memory model: one-cycle acknowledge, plus a bench poke port.
    always @(posedge clk) begin
        if (pk_en) bmem[pk_a[9:2]] <= pk_d;
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= bmem[mem_addr[9:2]];
            if (mem_we) bmem[mem_addr[9:2]] <= mem_wdata;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Sink back-pressure: stall one cycle in three.
    always @(negedge clk) begin
        cyc       <= cyc + 1;
        out_ready <= (cyc % 3) != 0;
    end

    // Output and cause monitor.
    always @(posedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) begin
                got_b[nb % 512] <= out_data;
                got_l[nb % 512] <= out_last;
                nb <= nb + 1;
            end
            if (cause_txbuf) ntb <= ntb + 1;
            if (cause_txend) nte <= nte + 1;
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); pk_en = 1'b1; pk_a = a; pk_d = d;
        @(negedge clk); pk_en = 1'b0;
    endtask

    task automatic wreg(input logic a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] at, input int len, input logic [31:0] cmd,
                            input logic [31:0] nxt, input logic [31:0] bp);
        poke(at,      {16'(len), 16'h0});
        poke(at + 4,  cmd);
        poke(at + 8,  nxt);
        poke(at + 12, bp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cur_ptr == 0,  "R1 cur_ptr", cur_ptr, 0);
        chk(!tx_demand,    "R1 tx_demand", tx_demand, 0);
        chk(!out_valid && !mem_req, "R1 valid/req", {out_valid, mem_req}, 0);
        chk(!cause_txbuf && !cause_txend, "R1 causes", {cause_txbuf, cause_txend}, 0);

        for (int w = 32'h200; w < 32'h400; w += 4)
            poke(w, {pat(w + 3), pat(w + 2), pat(w + 1), pat(w)});

        // Table-driven chains.
        for (int v = 0; v < NV; v++) begin
            int lens [3];
            int nd, b0, tb0, te0, el, k, nlast;
            logic [31:0] cmds [3];
            logic [31:0] bps  [3];
            lens[0] = VECS[v].l0; lens[1] = VECS[v].l1; lens[2] = VECS[v].l2;
            nd = VECS[v].nd;
            el = VECS[v].exp_len;
            for (int i = 0; i < nd; i++) begin
                cmds[i] = OWN | 32'h0000_0300 | 32'(i) | (i == 0 ? FST : 32'h0) |
                          ((i == nd - 1 && VECS[v].term_last) ? LST : 32'h0);
                bps[i]  = 32'h200 + 32'(64 * i) + 32'(VECS[v].off);
                put_desc(32'h100 + 32'(16 * i), lens[i], cmds[i],
                         (i == nd - 1) ? 32'h0 : 32'h100 + 32'(16 * (i + 1)), bps[i]);
            end
            b0 = nb; tb0 = ntb; te0 = nte;
            wreg(1'b0, 32'h100);
            wreg(1'b1, 32'h1);
            repeat (700) @(negedge clk);
            // R4 R7 R11: byte count
            chk(nb - b0 == el, $sformatf("R4 R7 R11 vec%0d length", v), nb - b0, el);
            k = 0;
            nlast = 0;
            for (int i = 0; i < nd; i++)
                for (int j = 0; j < lens[i]; j++) begin
                    if (k < el)
                        chk(got_b[(b0 + k) % 512] == pat(int'(bps[i]) + j),
                            $sformatf("R3 R12 vec%0d byte%0d", v, k),
                            got_b[(b0 + k) % 512], pat(int'(bps[i]) + j));
                    k++;
                end
            for (int k2 = 0; k2 < el; k2++) if (got_l[(b0 + k2) % 512]) nlast++;
            if (el > 0)
                chk(got_l[(b0 + el - 1) % 512] && nlast == 1,
                    $sformatf("R4 vec%0d last marker", v), nlast, 1);
            for (int i = 0; i < nd; i++)
                chk(bmem[(32'h104 + 16 * i) >> 2] == (cmds[i] & ~OWN),
                    $sformatf("%s vec%0d desc%0d status", (i == 0) ? "R6" : "R5", v, i),
                    bmem[(32'h104 + 16 * i) >> 2], cmds[i] & ~OWN);
            chk(cur_ptr == 0, $sformatf("R9 vec%0d cur_ptr", v), cur_ptr, 0);
            chk(!tx_demand, $sformatf("R9 vec%0d demand cleared", v), tx_demand, 0);
            chk(ntb - tb0 == (el != 0 ? 1 : 0), $sformatf("R8 vec%0d txbuf", v), ntb - tb0, el != 0);
            chk(nte - te0 == 1, $sformatf("R7 R9 vec%0d txend", v), nte - te0, 1);
        end

        // R2: first descriptor not owned.
        begin
            int b0, tb0, te0;
            put_desc(32'h1C0, 4, FST | LST | 32'h55, 32'h0, 32'h200);
            b0 = nb; tb0 = ntb; te0 = nte;
            wreg(1'b0, 32'h1C0);
            wreg(1'b1, 32'h1);
            repeat (100) @(negedge clk);
            chk(nb == b0, "R2 no bytes", nb - b0, 0);
            chk(bmem[32'h1C4 >> 2] == (FST | LST | 32'h55), "R2 status untouched", bmem[32'h1C4 >> 2], FST | LST | 32'h55);
            chk(cur_ptr == 32'h1C0 && tx_demand, "R2 pointer/demand kept", {cur_ptr, tx_demand}, {32'h1C0, 1'b1});
            chk(ntb == tb0 && nte == te0, "R2 no causes", ntb - tb0 + nte - te0, 0);
        end

        // R2: zero pointer.
        begin
            int b0;
            b0 = nb;
            wreg(1'b0, 32'h0);
            wreg(1'b1, 32'h1);
            repeat (50) @(negedge clk);
            chk(nb == b0 && tx_demand && cur_ptr == 0, "R2 zero pointer idle", {nb - b0, tx_demand}, 1);
        end

        // R10: two frames back to back, then a descriptor not yet owned.
        begin
            int b0, tb0, te0;
            put_desc(32'h180, 3, OWN | FST | LST, 32'h190, 32'h200);
            put_desc(32'h190, 4, OWN | FST | LST, 32'h1A0, 32'h245);
            put_desc(32'h1A0, 2, FST | LST, 32'h0, 32'h300);
            b0 = nb; tb0 = ntb; te0 = nte;
            wreg(1'b0, 32'h180);
            wreg(1'b1, 32'h1);
            repeat (400) @(negedge clk);
            chk(nb - b0 == 7, "R10 total bytes", nb - b0, 7);
            chk(got_l[(b0 + 2) % 512] && got_l[(b0 + 6) % 512], "R10 two end markers",
                {got_l[(b0 + 2) % 512], got_l[(b0 + 6) % 512]}, 2'b11);
            chk(got_b[(b0 + 3) % 512] == pat(32'h245), "R10 second frame byte", got_b[(b0 + 3) % 512], pat(32'h245));
            chk(ntb - tb0 == 2, "R10 txbuf count", ntb - tb0, 2);
            chk(nte == te0, "R10 no txend", nte - te0, 0);
            chk(cur_ptr == 32'h1A0 && tx_demand, "R10 stop at unowned", cur_ptr, 32'h1A0);
            chk(bmem[32'h184 >> 2] == (FST | LST) && bmem[32'h194 >> 2] == (FST | LST),
                "R6 both firsts released", bmem[32'h194 >> 2], FST | LST);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule